// File: doc/BRIEF.md
# Error-Interrupt Enable Set Command Register

This block holds the per-channel error-interrupt enable bitmap of a multi-channel transfer controller and gives software one byte-wide, write-only command register for setting bits in it. Software does not write the bitmap as data. It writes a command byte. The top bit of that byte is a skip flag. The lower seven bits name either one channel whose enable bit is to be set, or, for any value of 64 or more, all channels at once. A write can only set enable bits. Bits are removed only through a per-bit clear vector, which a companion clear-command register outside this block drives, or by reset.

The command byte sits at byte offset 0x1A from the controller base. The write bus is 32 bits wide and has four byte enables, so one word write can reach this byte together with its three neighbours in the word at 0x18. A neighbour that should be left alone carries the skip flag. The channel count is a parameter: 64 channels for the large variant and 32 for the small one. Any power of two from 2 to 64 is accepted. Reading the command register always returns zero. The bitmap is available as an output.

Top module: `irq_en_setter`

## Requirements
- R1: After reset every bit of `irq_en` is 0.
- R2: A decoded write whose command byte has bit 7 = 0, bit 6 = 0 and a value below N_CH in bits 5:0 sets `irq_en[value]` and leaves every other bit unchanged.
- R3: A decoded write whose command byte has bit 7 = 0 and bit 6 = 1 (values 64 to 127) sets every bit of `irq_en`.
- R4: A decoded write whose command byte has bit 7 = 1 leaves `irq_en` unchanged, whatever bits 6:0 hold.
- R5: When N_CH is below 64, command values from N_CH to 63 leave `irq_en` unchanged. For the 32-channel variant this is 32 to 63, the range in which the bit of weight 32 is set.
- R6: A write is decoded only when `wr_en` is 1, `wr_addr[ADDR_W-1:2]` equals the word holding offset 0x1A (word 0x18), and `wr_be[2]` is 1. The command byte is `wr_data[23:16]`. Bits `wr_addr[1:0]` and the other byte lanes have no effect.
- R7: Enable bits never go from 1 to 0 except through reset or the matching bit of `clr_mask`. A bit with `clr_mask` set and no set command in that cycle reads 0 in the next cycle.
- R8: If a set command and `clr_mask` target the same bit in the same cycle, the bit is 1 in the next cycle. The set wins.
- R9: `rd_data` is zero for every read, including reads of the command word.
- R10: The effect of a write or a clear appears on `irq_en` in the cycle after the clock edge at which `wr_en` or `clr_mask` was sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | ADDR_W | Byte address of the write |
| wr_data | input | 32 | Write data, lane n in bits 8n+7:8n |
| wr_be | input | 4 | Byte-lane enables |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Byte address of the read |
| rd_data | output | 32 | Read data, always zero |
| clr_mask | input | N_CH | Per-bit clear requests from the clear-command logic |
| irq_en | output | N_CH | Error-interrupt enable bitmap |

## Verification
The bitmap is held state that feeds `irq_en` directly. A decode error therefore shows up in the cycle after the faulty write: a wrong bit set, a bit missed, or a skipped or out-of-range command that changes something. Because bits are sticky, an error stays visible until a clear or reset removes it. The bench keeps a reference bitmap for both variants and compares the whole vector after every single write and every clear. It puts index-like values in the neighbouring byte lanes so that a decode from the wrong lane sets a bit that should stay clear.

// File: rtl/irqset_pkg.sv
package irqset_pkg;

   localparam int BUS_W   = 32;
   localparam int LANES   = BUS_W / 8;
   localparam int CODE_W  = 7;
   localparam int MAX_CH  = 64;

   // command byte: skip flag on top, 7-bit code below
   typedef struct packed {
      logic                skip;
      logic [CODE_W-1:0]   code;
   } cmd_byte_t;

   function automatic logic code_is_global(input logic [CODE_W-1:0] c);
      return c[CODE_W-1];
   endfunction

endpackage

// File: rtl/irqset_cmd_decode.sv
module irqset_cmd_decode
   import irqset_pkg::*;
#(
   parameter int                N_CH       = 64,
   parameter int                ADDR_W     = 12,
   parameter logic [ADDR_W-1:0] CMD_OFFSET = 'h1A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [BUS_W-1:0]  wr_data,
   input  logic [LANES-1:0]  wr_be,
   output logic [N_CH-1:0]   set_vec
);

   localparam int IDX_W = $clog2(N_CH);
   localparam int LANE  = int'(CMD_OFFSET[1:0]);

   logic        word_hit;
   logic        lane_hit;
   cmd_byte_t   cmd;
   logic        act;
   logic        glob;
   logic        idx_ok;
   logic [N_CH-1:0] set_one;

   assign word_hit = (wr_addr[ADDR_W-1:2] == CMD_OFFSET[ADDR_W-1:2]);
   assign lane_hit = wr_en && word_hit && wr_be[LANE];
   assign cmd      = cmd_byte_t'(wr_data[LANE*8 +: 8]);
   assign act      = lane_hit && !cmd.skip;
   assign glob     = act && code_is_global(cmd.code);

   // index range check depends on the variant
   generate
      if (N_CH == MAX_CH) begin : g_full
         assign idx_ok = act && !cmd.code[CODE_W-1];
      end else begin : g_small
         assign idx_ok = act && !cmd.code[CODE_W-1]
                         && (cmd.code[CODE_W-2:IDX_W] == '0);

         // R5
         unused_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (act && !cmd.code[CODE_W-1] && (cmd.code[CODE_W-2:0] >= (CODE_W-1)'(N_CH)))
               |-> (set_vec == '0))
            else $error("out-of-range index changed set vector");
      end
   endgenerate

   for (genvar i = 0; i < N_CH; i++) begin : g_onehot
      assign set_one[i] = idx_ok && (cmd.code[IDX_W-1:0] == IDX_W'(i));
   end

   assign set_vec = set_one | {N_CH{glob}};

   logic unused_dec;
   assign unused_dec = &{1'b0, wr_addr[1:0]};

   // R2
   single_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act && !cmd.code[CODE_W-1]) |-> $onehot0(set_vec))
      else $error("single-index command produced several set bits");

endmodule

// File: rtl/irqset_enable_bank.sv
module irqset_enable_bank #(
   parameter int N_CH = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] set_vec,
   input  logic [N_CH-1:0] clr_vec,
   output logic [N_CH-1:0] en_q
);

   // one flop per channel; set has priority over clear
   for (genvar i = 0; i < N_CH; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          en_q[i] <= 1'b0;
         else if (set_vec[i]) en_q[i] <= 1'b1;
         else if (clr_vec[i]) en_q[i] <= 1'b0;
      end
   end

   // R8
   set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_vec & clr_vec) != '0) |=>
         ((en_q & $past(set_vec & clr_vec)) == $past(set_vec & clr_vec)))
      else $error("clear overrode a set on the same bit");

   // R7
   sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_vec == '0) |=> ((en_q & $past(en_q)) == $past(en_q)))
      else $error("enable bit dropped without a clear");

   // R10
   set_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vec != '0) |=> ((en_q & $past(set_vec)) == $past(set_vec)))
      else $error("set not visible in following cycle");

endmodule

// File: rtl/irq_en_setter.sv
module irq_en_setter
   import irqset_pkg::*;
#(
   parameter int                N_CH       = 64,
   parameter int                ADDR_W     = 12,
   parameter logic [ADDR_W-1:0] CMD_OFFSET = 'h1A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [31:0]       wr_data,
   input  logic [3:0]        wr_be,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [31:0]       rd_data,
   input  logic [N_CH-1:0]   clr_mask,
   output logic [N_CH-1:0]   irq_en
);

   localparam int LANE = int'(CMD_OFFSET[1:0]);

   generate
      if (N_CH < 2 || N_CH > MAX_CH || (N_CH & (N_CH - 1)) != 0) begin : g_bad_nch
         $error("N_CH must be a power of two from 2 to 64");
      end
      if (ADDR_W < 3) begin : g_bad_aw
         $error("ADDR_W too small for a word address");
      end
   endgenerate

   logic [N_CH-1:0] set_vec;

   irqset_cmd_decode #(
      .N_CH       (N_CH),
      .ADDR_W     (ADDR_W),
      .CMD_OFFSET (CMD_OFFSET)
   ) u_dec (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .wr_be   (wr_be),
      .set_vec (set_vec)
   );

   irqset_enable_bank #(
      .N_CH (N_CH)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (clr_mask),
      .en_q    (irq_en)
   );

   // the command register is write-only: reads return zero
   assign rd_data = '0;

   logic unused_rd;
   assign unused_rd = &{1'b0, rd_en, rd_addr};

   // port-level view of a decoded command, for the checks below
   logic       cmd_hit;
   logic [7:0] cmd_b;
   assign cmd_hit = wr_en && (wr_addr[ADDR_W-1:2] == CMD_OFFSET[ADDR_W-1:2]) && wr_be[LANE];
   assign cmd_b   = wr_data[LANE*8 +: 8];

   // R3
   global_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_hit && !cmd_b[7] && cmd_b[6]) |=> (&irq_en))
      else $error("global set left a bit clear");

   // R4
   skip_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_hit && cmd_b[7] || !cmd_hit) && clr_mask == '0) |=> $stable(irq_en))
      else $error("bitmap changed without a live command");

endmodule

// File: tb/sim_irq_en_setter.sv
module sim_irq_en_setter;

   localparam int CLK_PERIOD = 10;
   localparam int AW = 12;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            wr_en = 1'b0;
   logic [AW-1:0]   wr_addr = '0;
   logic [31:0]     wr_data = '0;
   logic [3:0]      wr_be = '0;
   logic            rd_en = 1'b0;
   logic [AW-1:0]   rd_addr = '0;
   logic [31:0]     rd_data0, rd_data1;
   logic [63:0]     clr0 = '0;
   logic [31:0]     clr1 = '0;
   logic [63:0]     en0;
   logic [31:0]     en1;

   logic [63:0]     ref0 = '0;
   logic [63:0]     ref1 = '0;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_en_setter #(.N_CH(64), .ADDR_W(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_be(wr_be), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data0),
      .clr_mask(clr0), .irq_en(en0));

   irq_en_setter #(.N_CH(32), .ADDR_W(AW)) u1 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_be(wr_be), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data1),
      .clr_mask(clr1), .irq_en(en1));

   function automatic logic [63:0] all_mask(input int n);
      return (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
   endfunction

   function automatic logic [63:0] apply_cmd(input logic [63:0] cur, input int n, input logic [7:0] b);
      if (b[7])               return cur;
      if (b[6])               return cur | all_mask(n);
      if (int'(b[5:0]) < n)   return cur | (64'd1 << b[5:0]);
      return cur;
   endfunction

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic compare(input string req);
      check(en0 == ref0, {req, " (64ch)"}, en0, ref0);
      check({32'd0, en1} == ref1, {req, " (32ch)"}, {32'd0, en1}, ref1);
   endtask

   // one write; models updated only when it should decode
   task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
      @(negedge clk);
      wr_en = 1'b0; wr_be = '0;
      if (a[AW-1:2] == 10'h006 && be[2]) begin
         ref0 = apply_cmd(ref0, 64, d[23:16]);
         ref1 = apply_cmd(ref1, 32, d[23:16]);
      end
   endtask

   task automatic cmd(input logic [7:0] b);
      do_write(12'h018, {8'h07, b, 8'h05, 8'h03}, 4'hF);
   endtask

   task automatic do_reset;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      ref0 = '0; ref1 = '0;
      @(negedge clk);
   endtask

   task automatic t_reset;
      do_reset();
      compare("R1 reset");
   endtask

   task automatic t_single;
      cmd(8'd0);  compare("R2 index 0");
      cmd(8'd17); compare("R2 index 17");
      cmd(8'd31); compare("R2 index 31");
      cmd(8'd63); compare("R2 index 63");
      cmd(8'd40); compare("R2 index 40");
   endtask

   task automatic t_unused;
      do_reset();
      cmd(8'd32); compare("R5 value 32");
      cmd(8'd50); compare("R5 value 50");
      check(en1 == 32'd0, "R5 small variant untouched", {32'd0, en1}, 64'd0);
   endtask

   task automatic t_skip;
      do_reset();
      cmd(8'h80); compare("R4 skip with code 0");
      cmd(8'hC0); compare("R4 skip with global code");
      cmd(8'h85); compare("R4 skip with code 5");
      check(en0 == 64'd0, "R4 nothing set", en0, 64'd0);
   endtask

   task automatic t_global;
      do_reset();
      cmd(8'd3);
      cmd(8'd64); compare("R3 value 64");
      do_reset();
      cmd(8'd127); compare("R3 value 127");
      check(en0 == '1, "R3 all ones", en0, '1);
   endtask

   task automatic t_lanes;
      do_reset();
      do_write(12'h018, {8'h09, 8'h0B, 8'h05, 8'h03}, 4'b1011); compare("R6 lane 2 disabled");
      do_write(12'h01C, {8'h09, 8'h0B, 8'h05, 8'h03}, 4'hF);    compare("R6 other word");
      do_write(12'h014, {8'h09, 8'h0B, 8'h05, 8'h03}, 4'hF);    compare("R6 lower word");
      do_write(12'h01A, {8'h09, 8'h0C, 8'h05, 8'h03}, 4'b0100); compare("R6 byte address 0x1A");
      check(en0 == 64'h1000, "R6 only bit 12", en0, 64'h1000);
      // neighbours carry skip flags, one word write
      do_write(12'h018, {8'h80, 8'h0D, 8'h80, 8'h80}, 4'hF);    compare("R6 word with skipped neighbours");
   endtask

   task automatic t_clear;
      do_reset();
      cmd(8'd64);
      @(negedge clk);
      clr0 = 64'h0000_0000_0000_00F0; clr1 = 32'h0000_0F00;
      @(negedge clk);
      clr0 = '0; clr1 = '0;
      ref0 &= ~64'h00F0; ref1 &= ~64'h0F00;
      compare("R7 R10 clear next cycle");
      repeat (3) @(negedge clk);
      compare("R7 sticky while idle");
   endtask

   task automatic t_set_wins;
      do_reset();
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 12'h018; wr_data = {8'h00, 8'd9, 16'h0}; wr_be = 4'b0100;
      clr0 = 64'h0000_0000_0000_0200; clr1 = 32'h0000_0200;
      @(negedge clk);
      wr_en = 1'b0; wr_be = '0; clr0 = '0; clr1 = '0;
      ref0 = 64'h200; ref1 = 64'h200;
      compare("R8 set beats clear");
   endtask

   task automatic t_read;
      cmd(8'd64);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = 12'h018;
      #1;
      check(rd_data0 == 32'd0, "R9 read word 0x18 (64ch)", {32'd0, rd_data0}, 64'd0);
      check(rd_data1 == 32'd0, "R9 read word 0x18 (32ch)", {32'd0, rd_data1}, 64'd0);
      rd_addr = 12'h01A;
      #1;
      check(rd_data0 == 32'd0, "R9 read byte 0x1A", {32'd0, rd_data0}, 64'd0);
      rd_en = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_single();
      t_unused();
      t_skip();
      t_global();
      t_lanes();
      t_clear();
      t_set_wins();
      t_read();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule